// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block moves data words from a write clock domain to an unrelated read clock domain. Writes and reads are requested with active-low enables, which are sampled on the rising edge of their own clocks. The storage is a power-of-two array of `2**ADDR_W` words. The write and read pointers cross the domain boundary as Gray codes through two-flop synchronisers.

Three active-low level flags report how full the FIFO is:
- **Almost-full** (`paf_n`) and **half-full** (`hf_n`) are produced in the write domain.
- **Almost-empty** (`pae_n`) is produced in the read domain.

Each flag is computed on the side where a stale view of the other pointer can only make it assert early, never late. So each flag asserts on the same edge as the operation that crosses its threshold, and releases a few cycles later, once the other side's pointer has been synchronised. The almost-full offset `af_ofs` and the almost-empty offset `ae_ofs` are static inputs.

A static mode input selects the read behaviour:
- **Standard mode:** a read request loads the next word into `rd_data` on the accepting read edge.
- **Fall-through mode:** the head word is prefetched into the output register without a request, and each accepted read advances to the next word. Because that register holds a word of its own, the capacity grows by one and every level threshold moves up by one.

Change the mode and offsets only while both resets are held.

Top module: `afifo_flagged`

## Requirements
- R1: Let D = 2**ADDR_W. The capacity C is D words in standard mode (`fwft_mode`=0) and D+1 words in fall-through mode (`fwft_mode`=1). `full_n` goes low once the storage array holds D words. A write requested while `full_n` is low changes neither the stored data nor the count.
- R2: A read is not performed while `empty_n` is low. In standard mode `rd_data` then keeps its last value. A later write and read return the new word, showing that the read pointer did not move.
- R3: Words leave in the order they were written, with any ratio or phase between the two clocks and any stalling on either side.
- R4: In standard mode, a read accepted on a read-clock edge (`rd_en_n` low, `empty_n` high) presents the head word on `rd_data` right after that edge.
- R5: In fall-through mode, a word written into an empty FIFO appears on `rd_data` with `empty_n` high, without any read request. An accepted read replaces it with the next word, or drops `empty_n` if none is left.
- R6: `paf_n` is low when the count is C−m words or more and high when it is C−m−1 or fewer, where m = `af_ofs`. It goes low on the write edge that reaches the threshold.
- R7: `pae_n` is low when the count is at most n (standard) or n+1 (fall-through), and high above that, where n = `ae_ofs`. It goes low on the read edge that reaches the threshold.
- R8: `hf_n` is low when the count is at least D/2+1 (standard) or D/2+2 (fall-through), and high below that. It goes low on the write edge that reaches the threshold.
- R9: While `wr_rst_n` and `rd_rst_n` are low at clock edges (synchronous reset), both pointers clear and the flags take their empty values: `full_n`=1, `paf_n`=1, `hf_n`=1, `empty_n`=0, `pae_n`=0.
- R10: A flag released by an operation in the other domain returns high within six cycles of the slower clock after that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Low when the storage array is full |
| paf_n | output | 1 | Active-low almost-full flag |
| hf_n | output | 1 | Active-low half-full flag |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | DATA_W | Output word register |
| empty_n | output | 1 | Low when no word can be read |
| pae_n | output | 1 | Active-low almost-empty flag |
| fwft_mode | input | 1 | Static: 0 standard, 1 fall-through |
| af_ofs | input | ADDR_W+1 | Static almost-full offset m |
| ae_ofs | input | ADDR_W+1 | Static almost-empty offset n |

## Verification
The bound checker watches invariants that must hold on every edge:
- a full array blocks the write pointer;
- the write-side count never exceeds the mode's capacity;
- in standard mode an empty FIFO holds `rd_data` steady and keeps `pae_n` asserted;
- a full array always shows almost-full and half-full;
- reset drives the empty-state flag values.

The exact threshold counts, the prompt assertion on the crossing edge, the bounded release delay across domains, fall-through prefetch and end-to-end word order depend on sequences of operations. Only the directed scenarios of the bench can show these, and it runs them in both modes with the two clocks at unrelated rates.

// File: rtl/afifo_pkg.sv
// Package: shared types for the dual-clock flagged FIFO.
package afifo_pkg;
    // Read behaviour selected by the static mode input.
    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/afifo_sync.sv
// Two-flop synchroniser for a Gray-coded bus.
// Assumes the source changes by at most one bit per source clock, so every
// captured value is either the old or the new code.
module afifo_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture then re-register the foreign bus; synchronous reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_mem.sv
// Storage array: one synchronous write port, one asynchronous read port.
// Assumes the controllers never write a slot that is still unread.
module afifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_wr_ctl.sv
// Write-side controller: write pointer, full, almost-full and half-full.
// Counts against the synchronised read pointers, which can only lag, so the
// flags assert on the write edge that reaches a threshold and release late.
module afifo_wr_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  rd_mode_e          mode,
    input  logic [ADDR_W:0]   af_ofs,
    input  logic [ADDR_W+1:0] rmem_gray_s,
    input  logic [ADDR_W+1:0] rusr_gray_s,
    output logic              we,
    output logic [ADDR_W+1:0] wbin,
    output logic [ADDR_W+1:0] wgray,
    output logic [ADDR_W+1:0] level,
    output logic              full_n,
    output logic              paf_n,
    output logic              hf_n
);
    localparam int PW    = ADDR_W + 2;
    localparam int DEPTH = 1 << ADDR_W;

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] rmem_b, rusr_b, wbin_nx, mem_lvl_nx, lvl_nx;
    logic [PW-1:0] extra, cap, paf_thr, hf_thr;

    // Derive next-state counts and the mode-dependent thresholds.
    always_comb begin
        rmem_b     = gray2bin(rmem_gray_s);
        rusr_b     = gray2bin(rusr_gray_s);
        we         = req && full_n;
        wbin_nx    = wbin + {{(PW-1){1'b0}}, we};
        mem_lvl_nx = wbin_nx - rmem_b;
        lvl_nx     = wbin_nx - rusr_b;
        extra      = {{(PW-1){1'b0}}, mode == RD_FWFT};
        cap        = PW'(DEPTH) + extra;
        paf_thr    = cap - {1'b0, af_ofs};
        hf_thr     = PW'(DEPTH / 2 + 1) + extra;
        level      = wbin - rusr_b;
    end

    // Advance the pointer and register flags from the post-write count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
            paf_n  <= 1'b1;
            hf_n   <= 1'b1;
        end else begin
            wbin   <= wbin_nx;
            wgray  <= wbin_nx ^ (wbin_nx >> 1);
            full_n <= !(mem_lvl_nx == PW'(DEPTH));
            paf_n  <= !(lvl_nx >= paf_thr);
            hf_n   <= !(lvl_nx >= hf_thr);
        end
    end
endmodule

// File: rtl/afifo_rd_ctl.sv
// Read-side controller: array read pointer, user read pointer, output
// register control and the almost-empty flag.
// The array pointer marks slots freed for the writer. The user pointer marks
// words handed to the reader; it trails the array pointer by one while a
// prefetched word sits in the output register in fall-through mode.
module afifo_rd_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  rd_mode_e          mode,
    input  logic [ADDR_W:0]   ae_ofs,
    input  logic [ADDR_W+1:0] wgray_s,
    output logic              load,
    output logic [ADDR_W+1:0] rbin,
    output logic [ADDR_W+1:0] rmem_gray,
    output logic [ADDR_W+1:0] rusr_gray,
    output logic              empty_n,
    output logic              pae_n
);
    localparam int PW = ADDR_W + 2;

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] wb, rusr, rbin_nx, rusr_nx, lvl_nx, ae_thr;
    logic          ov, ov_nx, mem_ne, pop;

    // Decide pop/prefetch for the active mode and form next-state values.
    always_comb begin
        wb     = gray2bin(wgray_s);
        mem_ne = (wb != rbin);
        if (mode == RD_FWFT) begin
            pop   = req && ov;
            load  = mem_ne && (!ov || pop);
            ov_nx = load ? 1'b1 : (pop ? 1'b0 : ov);
        end else begin
            pop   = req && mem_ne;
            load  = pop;
            ov_nx = 1'b0;
        end
        rbin_nx = rbin + {{(PW-1){1'b0}}, load};
        rusr_nx = rusr + {{(PW-1){1'b0}}, pop};
        lvl_nx  = wb - rusr_nx;
        ae_thr  = {1'b0, ae_ofs} + {{(PW-1){1'b0}}, mode == RD_FWFT};
        empty_n = (mode == RD_FWFT) ? ov : mem_ne;
    end

    // Advance both pointers and register almost-empty from the post-read count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            rusr      <= '0;
            rmem_gray <= '0;
            rusr_gray <= '0;
            ov        <= 1'b0;
            pae_n     <= 1'b0;
        end else begin
            rbin      <= rbin_nx;
            rusr      <= rusr_nx;
            rmem_gray <= rbin_nx ^ (rbin_nx >> 1);
            rusr_gray <= rusr_nx ^ (rusr_nx >> 1);
            ov        <= ov_nx;
            pae_n     <= (lvl_nx > ae_thr);
        end
    end
endmodule

// File: rtl/afifo_flagged.sv
// Top: dual-clock FIFO with almost-full, half-full and almost-empty flags.
// Assumes fwft_mode, af_ofs and ae_ofs change only while both resets are held.
module afifo_flagged
    import afifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              paf_n,
    output logic              hf_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              pae_n,
    input  logic              fwft_mode,
    input  logic [ADDR_W:0]   af_ofs,
    input  logic [ADDR_W:0]   ae_ofs
);
    localparam int PW = ADDR_W + 2;

    rd_mode_e          mode;
    logic              we, load;
    logic [PW-1:0]     wbin, wgray, wr_level, rbin, rmem_gray, rusr_gray;
    logic [PW-1:0]     wgray_s, rmem_gray_s, rusr_gray_s;
    logic [DATA_W-1:0] mem_q;

    assign mode = rd_mode_e'(fwft_mode);

    afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .req(!wr_en_n), .mode(mode),
        .af_ofs(af_ofs), .rmem_gray_s(rmem_gray_s), .rusr_gray_s(rusr_gray_s),
        .we(we), .wbin(wbin), .wgray(wgray), .level(wr_level),
        .full_n(full_n), .paf_n(paf_n), .hf_n(hf_n)
    );

    afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .req(!rd_en_n), .mode(mode),
        .ae_ofs(ae_ofs), .wgray_s(wgray_s), .load(load), .rbin(rbin),
        .rmem_gray(rmem_gray), .rusr_gray(rusr_gray),
        .empty_n(empty_n), .pae_n(pae_n)
    );

    // Both read pointers cross together so they are sampled at one instant.
    afifo_sync #(.W(2 * PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .d({rmem_gray, rusr_gray}), .q({rmem_gray_s, rusr_gray_s})
    );

    afifo_sync #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
    );

    afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rbin[ADDR_W-1:0]), .rdata(mem_q)
    );

    // Output word register, loaded on a read (standard) or prefetch (fall-through).
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)  rd_data <= '0;
        else if (load)  rd_data <= mem_q;
    end
endmodule

// File: rtl/afifo_flagged_chk.sv
// Checker: per-cycle invariants of afifo_flagged, bound to every instance.
module afifo_flagged_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              full_n,
    input logic              paf_n,
    input logic              hf_n,
    input logic              empty_n,
    input logic              pae_n,
    input logic              fwft_mode,
    input logic [ADDR_W:0]   af_ofs,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W+1:0] wbin,
    input logic [ADDR_W+1:0] wr_level
);
    localparam int PW    = ADDR_W + 2;
    localparam int DEPTH = 1 << ADDR_W;

    // R1: a full array holds the write pointer.
    a_r1_no_write_when_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !full_n |=> $stable(wbin));

    // R1: the write-side count never exceeds the capacity of the mode.
    a_r1_level_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_level <= PW'(DEPTH) + {{(PW-1){1'b0}}, fwft_mode});

    // R2: standard mode keeps rd_data while empty.
    a_r2_hold_when_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fwft_mode && !empty_n) |=> $stable(rd_data));

    // R7: an empty FIFO in standard mode shows almost-empty.
    a_r7_empty_shows_pae: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fwft_mode && !empty_n) |-> !pae_n);

    // R6: a full array with a non-zero offset shows almost-full.
    a_r6_full_shows_paf: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!full_n && af_ofs != '0) |-> !paf_n);

    // R8: a full array shows half-full.
    a_r8_full_shows_hf: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !full_n |-> !hf_n);

    // R9: write-domain reset values.
    a_r9_wr_reset_flags: assert property (@(posedge wr_clk)
        !wr_rst_n |=> (full_n && paf_n && hf_n));

    // R9: read-domain reset values.
    a_r9_rd_reset_flags: assert property (@(posedge rd_clk)
        (!rd_rst_n && !wr_rst_n) |=> (!empty_n && !pae_n));
endmodule

bind afifo_flagged afifo_flagged_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .full_n(full_n), .paf_n(paf_n), .hf_n(hf_n), .empty_n(empty_n),
    .pae_n(pae_n), .fwft_mode(fwft_mode), .af_ofs(af_ofs), .rd_data(rd_data),
    .wbin(wbin), .wr_level(wr_level)
);

// File: tb/afifo_flagged_test.sv
// Directed bench for afifo_flagged: one task per scenario, each self-checking.
module afifo_flagged_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int D  = 1 << AW;
    localparam int M  = 3;
    localparam int N  = 2;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_en_n = 1, rd_en_n = 1;
    logic [DW-1:0] wr_data = '0;
    logic          fwft_mode = 0;
    logic [AW:0]   af_ofs = AW'(M), ae_ofs = AW'(N);
    logic [DW-1:0] rd_data;
    logic          full_n, paf_n, hf_n, empty_n, pae_n;

    int n_chk = 0, n_bad = 0;
    int cnt = 0;
    logic [DW-1:0] q[$];

    afifo_flagged #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .full_n(full_n), .paf_n(paf_n), .hf_n(hf_n),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .empty_n(empty_n), .pae_n(pae_n),
        .fwft_mode(fwft_mode), .af_ofs(af_ofs), .ae_ofs(ae_ofs)
    );

    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    always #(RD_PERIOD / 2)  rd_clk = ~rd_clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cap();
        return D + (fwft_mode ? 1 : 0);
    endfunction

    task automatic settle();
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic do_reset(input bit fwft);
        @(negedge wr_clk);
        wr_rst_n = 0; rd_rst_n = 0; wr_en_n = 1; rd_en_n = 1;
        fwft_mode = fwft;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        cnt = 0;
        q.delete();
        settle();
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en_n = 0; wr_data = d;
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    task automatic pop(output logic [DW-1:0] d);
        @(negedge rd_clk);
        if (fwft_mode) d = rd_data;
        rd_en_n = 0;
        @(negedge rd_clk);
        rd_en_n = 1;
        if (!fwft_mode) d = rd_data;
    endtask

    // Settled level check of all three programmable flags (R6, R7, R8, R10).
    task automatic check_levels();
        int ae = N + (fwft_mode ? 1 : 0);
        int hf = D / 2 + 1 + (fwft_mode ? 1 : 0);
        check(paf_n == !(cnt >= cap() - M), "R6/R10", "paf_n level", paf_n, !(cnt >= cap() - M));
        check(hf_n == !(cnt >= hf), "R8/R10", "hf_n level", hf_n, !(cnt >= hf));
        check(pae_n == (cnt > ae), "R7/R10", "pae_n level", pae_n, cnt > ae);
    endtask

    // R9: empty-state flag values after reset.
    task automatic t_reset();
        do_reset(0);
        check(full_n == 1, "R9", "full_n", full_n, 1);
        check(paf_n == 1, "R9", "paf_n", paf_n, 1);
        check(hf_n == 1, "R9", "hf_n", hf_n, 1);
        check(empty_n == 0, "R9", "empty_n", empty_n, 0);
        check(pae_n == 0, "R9", "pae_n", pae_n, 0);
    endtask

    // Fill to capacity and drain, checking every threshold on the way.
    task automatic t_thresholds(input bit fwft);
        logic [DW-1:0] d;
        do_reset(fwft);
        for (int i = 1; i <= cap(); i++) begin
            push(DW'(i * 7 + 1));
            q.push_back(DW'(i * 7 + 1));
            cnt++;
            if (cnt >= cap() - M)
                check(paf_n == 0, "R6", "paf_n prompt", paf_n, 0);
            if (cnt >= D / 2 + 1 + (fwft ? 1 : 0))
                check(hf_n == 0, "R8", "hf_n prompt", hf_n, 0);
            settle();
            check_levels();
            check(empty_n == 1, "R5", "empty_n after write", empty_n, 1);
            if (fwft)
                check(rd_data == q[0], "R5", "prefetched head", rd_data, q[0]);
        end
        check(full_n == 0, "R1", "full_n at capacity", full_n, 0);
        push(8'hEE);
        settle();
        check(full_n == 0, "R1", "full_n after refused write", full_n, 0);
        check_levels();
        while (q.size() > 0) begin
            logic [DW-1:0] e = q.pop_front();
            pop(d);
            cnt--;
            check(d == e, fwft ? "R5" : "R4", "read word", d, e);
            if (cnt <= N + (fwft ? 1 : 0))
                check(pae_n == 0, "R7", "pae_n prompt", pae_n, 0);
            settle();
            check_levels();
        end
        check(empty_n == 0, "R2", "empty_n when drained", empty_n, 0);
        d = rd_data;
        @(negedge rd_clk); rd_en_n = 0;
        @(negedge rd_clk); rd_en_n = 1;
        settle();
        check(empty_n == 0, "R2", "empty_n after refused read", empty_n, 0);
        if (!fwft)
            check(rd_data == d, "R2", "rd_data held", rd_data, d);
        push(8'h5A); cnt++;
        settle();
        pop(d); cnt--;
        check(d == 8'h5A, "R2", "word after refused read", d, 8'h5A);
    endtask

    // R3: concurrent stream with stalls on both sides, compared to a queue.
    task automatic t_stream(input bit fwft);
        int total = 60;
        int sent = 0, got = 0, wcyc = 0, rcyc = 0;
        bit pending = 0;
        do_reset(fwft);
        fork
            begin
                while (sent < total) begin
                    @(negedge wr_clk);
                    wcyc++;
                    if (full_n && (wcyc % 4 != 3)) begin
                        wr_en_n = 0; wr_data = DW'(sent * 13 + 5);
                        q.push_back(DW'(sent * 13 + 5));
                        sent++;
                    end else wr_en_n = 1;
                end
                @(negedge wr_clk);
                wr_en_n = 1;
            end
            begin
                while (got < total) begin
                    @(negedge rd_clk);
                    rcyc++;
                    if (!fwft && pending) begin
                        logic [DW-1:0] e = (q.size() > 0) ? q.pop_front() : 8'hXX;
                        check(rd_data == e, "R3", "stream word", rd_data, e);
                        got++;
                    end
                    if (got >= total) begin
                        rd_en_n = 1; pending = 0;
                    end else if (empty_n && (rcyc % 5 != 0)) begin
                        if (fwft) begin
                            logic [DW-1:0] e = (q.size() > 0) ? q.pop_front() : 8'hXX;
                            check(rd_data == e, "R3", "stream word", rd_data, e);
                            got++;
                        end
                        rd_en_n = 0; pending = 1;
                    end else begin
                        rd_en_n = 1; pending = 0;
                    end
                end
                @(negedge rd_clk);
                rd_en_n = 1;
            end
        join
        settle();
        check(empty_n == 0, "R3", "empty after stream", empty_n, 0);
    endtask

    initial begin
        t_reset();
        t_thresholds(0);
        t_thresholds(1);
        t_stream(0);
        t_stream(1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule